// File: doc/BRIEF.md
# Programmable Eight-Input Interrupt Controller

This block collects eight interrupt request lines and presents one interrupt to a processor. A pending request is raised to the processor only when it outranks every line already being serviced. When the processor acknowledges, the controller marks the winning line as in service and drives an 8-bit vector. The vector's upper five bits come from a programmed base and its lower three bits are the line number. The controller is programmed through two 8-bit ports on a small register bus, selected by one address bit. Address 0 is the command port and address 1 is the data port.

After reset the controller is quiet until software writes an initialization sequence. A command-port write with bit 4 set opens the sequence. The data port then takes the base vector, then a cascade word if cascaded operation was chosen, then a mode word if one was announced. The state machine walks these transitions:
- SEQ_BLANK to SEQ_BASE on the opening word. The opening word also takes the machine to SEQ_BASE from any other state.
- SEQ_BASE to SEQ_CASC, SEQ_MODE or SEQ_RUN on the base word.
- SEQ_CASC to SEQ_MODE or SEQ_RUN on the cascade word.
- SEQ_MODE to SEQ_RUN on the mode word.

In SEQ_RUN the data port writes the mask, and command-port words handle end-of-interrupt, priority rotation and register read selection. A master controller can have a second controller wired to one chosen input. When that input is acknowledged, the master passes the acknowledge on and forwards the second controller's vector.

Top module: `intc_top`

## Requirements
- R1: After reset the interrupt output is low, both read ports return 0x00, and no vector is granted until initialization completes.
- R2: A command write with bit 4 set starts initialization and clears the mask, the in-service register, the latched requests and the read selection. Its bit 1 = 0 asks for a cascade word, bit 0 = 1 asks for a mode word, and bit 3 chooses level triggering. Data writes then take the base, the optional cascade word and the optional mode word in that order. Until the last expected word arrives, the interrupt output stays low and the data writes never reach the mask.
- R3: In edge mode a request is latched on a low-to-high input change and cleared by its acknowledge. A line already high when initialization starts makes no request until it rises again.
- R4: In level mode the request register follows the input lines directly, so a line that falls withdraws its request. A line still high after its end-of-interrupt requests again.
- R5: The interrupt output is high when an unmasked pending line outranks every in-service line. After initialization line 0 ranks highest and line 7 lowest.
- R6: An acknowledge while the output is high sets the winner's in-service bit and yields the vector {base[7:3], line}.
- R7: An acknowledge while the output is low yields base with the low three bits all ones and changes no register.
- R8: Data writes in the running state set the mask. A set mask bit blocks that line, and data-port reads return the mask.
- R9: A command write with bits 4:3 = 01 and bit 1 = 1 selects the register that command-port reads return. Bit 0 = 1 selects in-service and bit 0 = 0 selects requests.
- R10: A command write with bits 7:5 = 001 clears the highest-ranked in-service bit. Bits 7:5 = 011 clears the in-service bit of the line in bits 2:0.
- R11: Bits 7:5 = 101 and 111 perform the same clears as 001 and 011, and also make the cleared line rank lowest. Bits 7:5 = 110 makes the line in bits 2:0 rank lowest.
- R12: When the role input is high and cascaded operation was chosen, acknowledging the input named by the cascade word's bits 2:0 pulses the downstream acknowledge. The vector is then the downstream vector input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 1 | Port select: 0 command, 1 data |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected port |
| irq_in | input | 8 | Request lines |
| int_out | output | 1 | Interrupt to the processor |
| int_ack | input | 1 | Acknowledge, one cycle |
| vec_out | output | 8 | Vector, valid while int_ack is high |
| role_master | input | 1 | High when this controller is a cascade master |
| slv_ack | output | 1 | Acknowledge passed to the downstream controller |
| slv_vec_in | input | 8 | Vector from the downstream controller |

## Verification
The bench targets the following corner cases:
- **Nested priority.** A lower line stays pending while a higher one is in service. A design that ignored in-service state would interrupt again and grant line 5 inside line 2's handler.
- **Rotation.** After a rotating end-of-interrupt, line 3 must beat line 0. A fixed-priority design would return vector 0x40 instead of 0x43, and it would also clear the wrong in-service bit on the next non-specific end-of-interrupt.
- **Initialization.** The bench checks that the mode word does not land in the mask, that a line held high across re-initialization stays silent in edge mode, and that a level line re-requests after its end-of-interrupt.
- **Acknowledge routing.** A spurious acknowledge must return the all-ones line, and only the cascade line may route its acknowledge downstream.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [2:0] {
        SEQ_BLANK,
        SEQ_BASE,
        SEQ_CASC,
        SEQ_MODE,
        SEQ_RUN
    } seq_state_t;

    typedef enum logic [2:0] {
        OP_EOI_ANY  = 3'b001,
        OP_EOI_LINE = 3'b011,
        OP_ROT_ANY  = 3'b101,
        OP_ROT_LINE = 3'b111,
        OP_SET_LOW  = 3'b110
    } eoi_op_t;

endpackage

// File: rtl/intc_seq.sv
module intc_seq
    import intc_pkg::*;
#(
    parameter int LINES = 8,
    localparam int LW = $clog2(LINES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_wr,
    input  logic                data_wr,
    input  logic [LINES-1:0]    wdata,
    output logic                running,
    output logic                init_start,
    output logic [LINES-LW-1:0] base_hi,
    output logic                cascaded,
    output logic                level_mode,
    output logic [LW-1:0]       cas_line
);

    seq_state_t state_q, state_d;
    logic need_mode_q, single_q, level_q;
    logic [LINES-LW-1:0] base_q;
    logic [LW-1:0] casl_q;
    logic open_word;

    assign open_word = cmd_wr && wdata[4];

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (open_word) begin
            state_d = SEQ_BASE;
        end else begin
            unique case (state_q)
                SEQ_BLANK: state_d = SEQ_BLANK;
                SEQ_BASE: begin
                    if (data_wr) begin
                        if (!single_q)        state_d = SEQ_CASC;
                        else if (need_mode_q) state_d = SEQ_MODE;
                        else                  state_d = SEQ_RUN;
                    end
                end
                SEQ_CASC: begin
                    if (data_wr) state_d = need_mode_q ? SEQ_MODE : SEQ_RUN;
                end
                SEQ_MODE: begin
                    if (data_wr) state_d = SEQ_RUN;
                end
                SEQ_RUN:  state_d = SEQ_RUN;
                default:  state_d = SEQ_BLANK;
            endcase
        end
    end

    // state and configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= SEQ_BLANK;
            need_mode_q <= 1'b0;
            single_q    <= 1'b1;
            level_q     <= 1'b0;
            base_q      <= '0;
            casl_q      <= '0;
        end else begin
            state_q <= state_d;
            if (open_word) begin
                need_mode_q <= wdata[0];
                single_q    <= wdata[1];
                level_q     <= wdata[3];
            end
            if (state_q == SEQ_BASE && data_wr && !open_word)
                base_q <= wdata[LINES-1:LW];
            if (state_q == SEQ_CASC && data_wr && !open_word)
                casl_q <= wdata[LW-1:0];
        end
    end

    // outputs
    always_comb begin
        running    = (state_q == SEQ_RUN);
        init_start = open_word;
        base_hi    = base_q;
        cascaded   = !single_q;
        level_mode = level_q;
        cas_line   = casl_q;
    end

endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
    parameter int LINES = 8,
    localparam int LW = $clog2(LINES)
) (
    input  logic [LINES-1:0] vec,
    input  logic [LW-1:0]    low,
    output logic             hit,
    output logic [LW-1:0]    idx,
    output logic [LW-1:0]    rank
);

    logic [LW-1:0] pos;

    // scan from lowest rank to highest so the last hit wins
    always_comb begin
        hit = 1'b0;
        idx = '0;
        pos = '0;
        for (int k = LINES - 1; k >= 0; k--) begin
            pos = LW'(low + LW'(1) + LW'(k));
            if (vec[pos]) begin
                hit = 1'b1;
                idx = pos;
            end
        end
        rank = LW'(idx - low - LW'(1));
    end

endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int LINES = 8,
    localparam int LW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_addr,
    input  logic             bus_wr,
    input  logic [LINES-1:0] bus_wdata,
    output logic [LINES-1:0] bus_rdata,
    input  logic [LINES-1:0] irq_in,
    output logic             int_out,
    input  logic             int_ack,
    output logic [LINES-1:0] vec_out,
    input  logic             role_master,
    output logic             slv_ack,
    input  logic [LINES-1:0] slv_vec_in
);

    logic cmd_wr, data_wr;
    logic running, init_start, cascaded, level_mode;
    logic [LINES-LW-1:0] base_hi;
    logic [LW-1:0] cas_line;

    logic [LINES-1:0] irq_q, edge_q, edge_d, isr_q, isr_d, mask_q, mask_d;
    logic [LINES-1:0] req, cand;
    logic [LW-1:0] low_q, low_d;
    logic rsel_q, rsel_d;

    logic req_hit, isr_hit, ack_take, to_slave;
    logic [LW-1:0] win, win_rank, top, top_rank;
    eoi_op_t op;

    assign cmd_wr  = bus_wr && !bus_addr;
    assign data_wr = bus_wr && bus_addr;

    intc_seq #(.LINES(LINES)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr),
        .wdata(bus_wdata), .running(running), .init_start(init_start),
        .base_hi(base_hi), .cascaded(cascaded), .level_mode(level_mode),
        .cas_line(cas_line)
    );

    assign req  = level_mode ? irq_in : edge_q;
    assign cand = req & ~mask_q;

    intc_prio #(.LINES(LINES)) u_req_prio (
        .vec(cand), .low(low_q), .hit(req_hit), .idx(win), .rank(win_rank)
    );

    intc_prio #(.LINES(LINES)) u_isr_prio (
        .vec(isr_q), .low(low_q), .hit(isr_hit), .idx(top), .rank(top_rank)
    );

    assign int_out  = running && req_hit && (!isr_hit || (win_rank < top_rank));
    assign ack_take = int_ack && int_out;
    assign to_slave = cascaded && role_master && (win == cas_line);
    assign slv_ack  = ack_take && to_slave;
    assign op       = eoi_op_t'(bus_wdata[LINES-1:LINES-3]);

    always_comb begin
        if (!int_out)      vec_out = {base_hi, {LW{1'b1}}};
        else if (to_slave) vec_out = slv_vec_in;
        else               vec_out = {base_hi, win};
    end

    always_comb begin
        bus_rdata = bus_addr ? mask_q : (rsel_q ? isr_q : req);
    end

    // register updates
    always_comb begin
        edge_d = (edge_q | (irq_in & ~irq_q));
        isr_d  = isr_q;
        mask_d = mask_q;
        low_d  = low_q;
        rsel_d = rsel_q;
        if (init_start) begin
            edge_d = '0;
            isr_d  = '0;
            mask_d = '0;
            low_d  = LW'(LINES - 1);
            rsel_d = 1'b0;
        end else if (running) begin
            if (data_wr) mask_d = bus_wdata;
            if (cmd_wr && bus_wdata[4:3] == 2'b01 && bus_wdata[1])
                rsel_d = bus_wdata[0];
            if (cmd_wr && bus_wdata[4:3] == 2'b00) begin
                unique case (op)
                    OP_EOI_ANY:  if (isr_hit) isr_d[top] = 1'b0;
                    OP_ROT_ANY: begin
                        if (isr_hit) begin
                            isr_d[top] = 1'b0;
                            low_d = top;
                        end
                    end
                    OP_EOI_LINE: isr_d[bus_wdata[LW-1:0]] = 1'b0;
                    OP_ROT_LINE: begin
                        isr_d[bus_wdata[LW-1:0]] = 1'b0;
                        low_d = bus_wdata[LW-1:0];
                    end
                    OP_SET_LOW:  low_d = bus_wdata[LW-1:0];
                    default: ;
                endcase
            end
            if (ack_take) begin
                isr_d[win]  = 1'b1;
                edge_d[win] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q  <= '0;
            edge_q <= '0;
            isr_q  <= '0;
            mask_q <= '0;
            low_q  <= LW'(LINES - 1);
            rsel_q <= 1'b0;
        end else begin
            irq_q  <= irq_in;
            edge_q <= edge_d;
            isr_q  <= isr_d;
            mask_q <= mask_d;
            low_q  <= low_d;
            rsel_q <= rsel_d;
        end
    end

endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
    parameter int LINES = 8,
    localparam int LW = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             init_start,
    input logic             int_out,
    input logic             int_ack,
    input logic             slv_ack,
    input logic             role_master,
    input logic [LINES-1:0] mask_q,
    input logic [LINES-1:0] isr_q,
    input logic [LINES-1:0] cand,
    input logic [LW-1:0]    win,
    input logic [LINES-1:0] vec_out
);

    assert_isr_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (isr_q == '0));

    assert_mask_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !init_start) |=> $stable(mask_q));

    assert_ack_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_out && !init_start) |=> isr_q[$past(win)]);

    assert_winner_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (cand[win] && !mask_q[win]));

    assert_spurious_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !int_out) |-> (vec_out[LW-1:0] == {LW{1'b1}}));

    assert_route_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
        slv_ack |-> (int_ack && role_master && int_out));

endmodule

bind intc_top intc_chk #(.LINES(LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .running(running), .init_start(init_start),
    .int_out(int_out), .int_ack(int_ack), .slv_ack(slv_ack),
    .role_master(role_master), .mask_q(mask_q), .isr_q(isr_q),
    .cand(cand), .win(win), .vec_out(vec_out)
);

// File: tb/sim_intc_top.sv
module sim_intc_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = '0;
    logic       int_out;
    logic       int_ack = 1'b0;
    logic [7:0] vec_out;
    logic       role_master = 1'b1;
    logic       slv_ack;
    logic [7:0] slv_vec_in = 8'h9A;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    intc_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .int_out(int_out), .int_ack(int_ack), .vec_out(vec_out),
        .role_master(role_master), .slv_ack(slv_ack), .slv_vec_in(slv_vec_in)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
        #1;
    endtask

    task automatic ack(output logic [7:0] v, output logic s);
        @(negedge clk);
        int_ack = 1'b1;
        #1;
        v = vec_out;
        s = slv_ack;
        @(negedge clk);
        int_ack = 1'b0;
        #1;
    endtask

    task automatic chk_int(input string tag, input logic exp);
        #1;
        chk(tag, {7'd0, int_out}, {7'd0, exp});
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk_int("R1 int after reset", 1'b0);
        rd(1'b1, d); chk("R1 data read", d, 8'h00);
        rd(1'b0, d); chk("R1 cmd read", d, 8'h00);
    endtask

    task automatic t_basic();
        logic [7:0] d, v;
        logic s;
        wr(1'b0, 8'h12);
        set_irq(8'h08);
        chk_int("R2 quiet mid-init", 1'b0);
        wr(1'b1, 8'h40);
        chk_int("R3 edge latched", 1'b1);
        rd(1'b0, d); chk("R9 request read", d, 8'h08);
        ack(v, s); chk("R6 vector", v, 8'h43);
        chk_int("R6 quiet after ack", 1'b0);
        rd(1'b0, d); chk("R3 cleared by ack", d, 8'h00);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R9 in-service read", d, 8'h08);
        wr(1'b0, 8'h20);
        rd(1'b0, d); chk("R10 eoi clears", d, 8'h00);
        set_irq(8'h00);
    endtask

    task automatic t_nest();
        logic [7:0] d, v;
        logic s;
        set_irq(8'h24);
        ack(v, s); chk("R5 line2 first", v, 8'h42);
        chk_int("R5 line5 held off", 1'b0);
        set_irq(8'h25);
        chk_int("R5 line0 preempts", 1'b1);
        ack(v, s); chk("R5 line0 vector", v, 8'h40);
        rd(1'b0, d); chk("R6 isr nested", d, 8'h05);
        wr(1'b0, 8'h20);
        rd(1'b0, d); chk("R10 ns clears top", d, 8'h04);
        chk_int("R5 line5 still held", 1'b0);
        wr(1'b0, 8'h62);
        rd(1'b0, d); chk("R10 specific clears", d, 8'h00);
        ack(v, s); chk("R5 line5 vector", v, 8'h45);
        wr(1'b0, 8'h20);
        set_irq(8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] d, v;
        logic s;
        wr(1'b1, 8'h10);
        rd(1'b1, d); chk("R8 mask read", d, 8'h10);
        set_irq(8'h10);
        chk_int("R8 masked quiet", 1'b0);
        wr(1'b1, 8'h00);
        chk_int("R8 unmasked", 1'b1);
        ack(v, s); chk("R8 vector", v, 8'h44);
        wr(1'b0, 8'h20);
        set_irq(8'h00);
    endtask

    task automatic t_spurious();
        logic [7:0] d, v;
        logic s;
        chk_int("R7 idle", 1'b0);
        ack(v, s); chk("R7 vector", v, 8'h47);
        chk("R7 no route", {7'd0, s}, 8'h00);
        rd(1'b0, d); chk("R7 isr unchanged", d, 8'h00);
    endtask

    task automatic t_rotate();
        logic [7:0] d, v;
        logic s;
        set_irq(8'h42);
        ack(v, s); chk("R11 line1", v, 8'h41);
        wr(1'b0, 8'hA0);
        ack(v, s); chk("R11 line6", v, 8'h46);
        set_irq(8'h4B);
        chk_int("R11 line3 beats 6", 1'b1);
        ack(v, s); chk("R11 rotated order", v, 8'h43);
        wr(1'b0, 8'h20);
        rd(1'b0, d); chk("R11 ns by rank", d, 8'h40);
        chk_int("R11 line0 below 6", 1'b0);
        wr(1'b0, 8'hE6);
        ack(v, s); chk("R11 line0 after rot", v, 8'h40);
        wr(1'b0, 8'h20);
        set_irq(8'h00);
        wr(1'b0, 8'hC7);
        set_irq(8'h81);
        ack(v, s); chk("R11 set low fixed", v, 8'h40);
        wr(1'b0, 8'h20);
        ack(v, s); chk("R11 line7 last", v, 8'h47);
        wr(1'b0, 8'h20);
        set_irq(8'h00);
    endtask

    task automatic t_reinit();
        logic [7:0] d, v;
        logic s;
        set_irq(8'h10);
        ack(v, s); chk("R6 pre-init", v, 8'h44);
        wr(1'b0, 8'h12);
        wr(1'b1, 8'h48);
        rd(1'b0, d); chk("R3 held line silent", d, 8'h00);
        chk_int("R3 no int", 1'b0);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R2 isr cleared", d, 8'h00);
        set_irq(8'h00);
    endtask

    task automatic t_level_casc();
        logic [7:0] d, v;
        logic s;
        wr(1'b0, 8'h19);
        wr(1'b1, 8'h80);
        set_irq(8'h20);
        chk_int("R2 quiet before casc", 1'b0);
        wr(1'b1, 8'h02);
        chk_int("R2 quiet before mode", 1'b0);
        wr(1'b1, 8'h01);
        chk_int("R4 level request", 1'b1);
        rd(1'b1, d); chk("R2 mode word not mask", d, 8'h00);
        set_irq(8'h00);
        chk_int("R4 withdrawn", 1'b0);
        set_irq(8'h04);
        ack(v, s); chk("R12 forwarded vector", v, 8'h9A);
        chk("R12 route pulse", {7'd0, s}, 8'h01);
        set_irq(8'h00);
        wr(1'b0, 8'h20);
        set_irq(8'h20);
        ack(v, s); chk("R12 own vector", v, 8'h85);
        chk("R12 no route", {7'd0, s}, 8'h00);
        wr(1'b0, 8'h20);
        chk_int("R4 re-request", 1'b1);
        set_irq(8'h00);
        chk_int("R4 dropped", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_nest();
        t_mask();
        t_spurious();
        t_rotate();
        t_reinit();
        t_level_casc();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule